// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a down-counting interval timer for a contactless reader front end. A prescaler divides the system clock by an odd or even ratio taken from a 12-bit divisor. The divisor arrives as a 4-bit upper part and an 8-bit lower part, because the two parts live in different configuration registers. Each prescaler tick decrements a 16-bit count. When the count expires, the block raises a sticky interrupt flag and emits a one-cycle expiry pulse. It then either stops at zero or reloads and keeps counting, depending on the auto-restart setting.

Software starts or halts the timer with single-cycle strobes. In automatic mode the surrounding protocol logic controls it instead: an end-of-transmit pulse starts the timer, and a pulse marking the fifth received bit stops it, unless multi-frame reception is enabled. An optional gate can pause counting. The gate follows one of two external inputs, selected by a 2-bit field. The reload value is captured only at a start, so writes to it during a run do not disturb the current run.

Control is a three-state machine:
- **IDLE**: stopped.
- **RUN**: counting.
- **HOLD**: enabled but paused by the gate.

Its transitions are:
- **start**: IDLE to RUN when the gate is open, or IDLE to HOLD when it is closed.
- **gate closes**: RUN to HOLD.
- **gate opens**: HOLD to RUN.
- **halt**: RUN or HOLD to IDLE, on a stop event or on a final expiry without auto-restart.

Top module: `ptimer_top`

## Requirements
- R1: After reset the timer is idle: `running`=0, `irq_flag`=0, count bytes 0.
- R2: With P = {`psc_hi`,`psc_lo`}, a tick occurs every 2P+1 cycles when `even_div`=0 and every 2P+2 cycles when `even_div`=1. The first decrement after a start happens that many cycles after the start edge.
- R3: A start loads `reload` into the count on the next edge. Later changes to `reload` have no effect, including on auto-restart reloads, until the next start. A start while already running reloads the count.
- R4: With `auto_restart`=0, the tick that takes the count from 1 (or from 0) expires. The count becomes 0, `expire` pulses for one cycle, `irq_flag` is set and `running` drops.
- R5: With `auto_restart`=1, an expiring tick reloads the value captured at start and the timer keeps running. Each period of N ticks (N = captured value) gives exactly one `expire` pulse.
- R6: `stop_now` halts the timer at the next edge and holds the count. A stop wins over a start in the same cycle. While idle, the count does not change.
- R7: With `auto_mode`=1, `tx_end` starts the timer, and `rx_bit5` stops it unless `multi_rx`=1. With `auto_mode`=0, `tx_end` has no effect.
- R8: `gate_sel` encodes 0 = ungated, 1 = gated by `gate_a` (high = count), 2 = gated by `gate_b`, and 3 = ungated. While the gate is closed, the count and prescaler hold and `running` stays 1.
- R9: `irq_clr` clears `irq_flag`. An expiry in the same cycle wins, and the flag stays 1.
- R10: `count_hi` shows count bits 15:8 and `count_lo` shows bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_now | input | 1 | Immediate start strobe |
| stop_now | input | 1 | Immediate stop strobe |
| tx_end | input | 1 | End-of-transmit pulse from protocol logic |
| rx_bit5 | input | 1 | Fifth-received-bit pulse from protocol logic |
| auto_mode | input | 1 | Protocol-driven start/stop enable |
| multi_rx | input | 1 | Multi-frame reception; blocks the automatic stop |
| auto_restart | input | 1 | Reload on expiry instead of stopping |
| gate_sel | input | 2 | Gate source select |
| gate_a | input | 1 | First gate input |
| gate_b | input | 1 | Second gate input |
| even_div | input | 1 | Select 2P+2 division instead of 2P+1 |
| psc_hi | input | 4 | Upper divisor bits |
| psc_lo | input | 8 | Lower divisor bits |
| reload | input | 16 | Reload value |
| irq_clr | input | 1 | Clear the interrupt flag |
| running | output | 1 | Timer enabled (RUN or HOLD) |
| expire | output | 1 | One-cycle expiry pulse |
| irq_flag | output | 1 | Sticky timer interrupt flag |
| count_hi | output | 8 | Count bits 15:8 |
| count_lo | output | 8 | Count bits 7:0 |

## Verification
The assertions assume the following about the inputs:
- Strobes and protocol pulses are synchronous to `clk`.
- The gate inputs are already synchronised.
- `reload` and `auto_restart` are sampled in the same cycle as the event they qualify.

The bench keeps within these assumptions by driving every input on the falling edge and holding each strobe for exactly one cycle. It changes divisor, gating and reload settings only between scenarios, or deliberately mid-run where R3 requires it.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } tmr_state_e;

    localparam logic [1:0] GSEL_NONE = 2'd0;
    localparam logic [1:0] GSEL_A    = 2'd1;
    localparam logic [1:0] GSEL_B    = 2'd2;
endpackage

// File: rtl/ptimer_prescaler.sv
module ptimer_prescaler #(
    parameter int PSC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             even_div,
    input  logic [PSC_W-1:0] psc_val,
    output logic             tick
);
    localparam int DIV_W = PSC_W + 1;

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last;

    // terminal value is divisor minus one: 2P for odd, 2P+1 for even
    assign last = {psc_val, 1'b0} + DIV_W'(even_div);
    assign tick = en & (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (en)
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/ptimer_gate.sv
module ptimer_gate
    import ptimer_pkg::*;
(
    input  logic [1:0] gate_sel,
    input  logic       gate_a,
    input  logic       gate_b,
    output logic       gate_open
);
    always_comb begin
        unique case (gate_sel)
            GSEL_A:  gate_open = gate_a;
            GSEL_B:  gate_open = gate_b;
            default: gate_open = 1'b1;
        endcase
    end
endmodule

// File: rtl/ptimer_ctrl.sv
module ptimer_ctrl
    import ptimer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_evt,
    input  logic stop_evt,
    input  logic gate_open,
    input  logic final_exp,
    output logic running,
    output logic count_en
);
    tmr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_evt && !stop_evt)
                    state_d = gate_open ? ST_RUN : ST_HOLD;
            end
            ST_RUN: begin
                if (stop_evt || final_exp)
                    state_d = ST_IDLE;
                else if (!gate_open)
                    state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (stop_evt || final_exp)
                    state_d = ST_IDLE;
                else if (gate_open)
                    state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        running  = (state_q != ST_IDLE);
        count_en = running && gate_open;
    end
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top #(
    parameter int CNT_W    = 16,
    parameter int PSC_HI_W = 4,
    parameter int PSC_LO_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_now,
    input  logic                  stop_now,
    input  logic                  tx_end,
    input  logic                  rx_bit5,
    input  logic                  auto_mode,
    input  logic                  multi_rx,
    input  logic                  auto_restart,
    input  logic [1:0]            gate_sel,
    input  logic                  gate_a,
    input  logic                  gate_b,
    input  logic                  even_div,
    input  logic [PSC_HI_W-1:0]   psc_hi,
    input  logic [PSC_LO_W-1:0]   psc_lo,
    input  logic [CNT_W-1:0]      reload,
    input  logic                  irq_clr,
    output logic                  running,
    output logic                  expire,
    output logic                  irq_flag,
    output logic [CNT_W/2-1:0]    count_hi,
    output logic [CNT_W/2-1:0]    count_lo
);
    localparam int PSC_W  = PSC_HI_W + PSC_LO_W;
    localparam int HALF_W = CNT_W / 2;

    logic             start_evt, stop_evt, load;
    logic             gate_open, count_en, tick, final_exp;
    logic [CNT_W-1:0] cnt_q, shadow_q;

    assign start_evt = start_now | (auto_mode & tx_end);
    assign stop_evt  = stop_now  | (auto_mode & rx_bit5 & ~multi_rx);
    assign load      = start_evt & ~stop_evt;
    assign expire    = tick & ~stop_evt & ~load & (cnt_q <= CNT_W'(1));
    assign final_exp = expire & ~auto_restart;

    ptimer_gate u_gate (
        .gate_sel (gate_sel),
        .gate_a   (gate_a),
        .gate_b   (gate_b),
        .gate_open(gate_open)
    );

    ptimer_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_evt(start_evt),
        .stop_evt (stop_evt),
        .gate_open(gate_open),
        .final_exp(final_exp),
        .running  (running),
        .count_en (count_en)
    );

    ptimer_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (count_en),
        .clr     (load),
        .even_div(even_div),
        .psc_val ({psc_hi, psc_lo}),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            shadow_q <= '0;
        end else if (load) begin
            cnt_q    <= reload;
            shadow_q <= reload;
        end else if (tick && !stop_evt) begin
            if (cnt_q <= CNT_W'(1))
                cnt_q <= auto_restart ? shadow_q : '0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_flag <= 1'b0;
        else if (expire)
            irq_flag <= 1'b1;
        else if (irq_clr)
            irq_flag <= 1'b0;
    end

    assign count_hi = cnt_q[CNT_W-1 -: HALF_W];
    assign count_lo = cnt_q[HALF_W-1:0];
endmodule

// File: rtl/ptimer_checker.sv
module ptimer_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_evt,
    input logic             load,
    input logic             expire,
    input logic             auto_restart,
    input logic             irq_flag,
    input logic             running,
    input logic             gate_open,
    input logic [CNT_W-1:0] reload,
    input logic [CNT_W-1:0] cnt_q
);
    assert_start_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(reload)) && running);

    assert_final_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !auto_restart) |=> (!running && cnt_q == '0));

    assert_irq_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq_flag);

    assert_restart_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && auto_restart) |=> running);

    assert_stop_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !running);

    assert_idle_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !load) |=> $stable(cnt_q));

    assert_gate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !gate_open && !load && !stop_evt) |=> ($stable(cnt_q) && running));
endmodule

bind ptimer_top ptimer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_evt    (stop_evt),
    .load        (load),
    .expire      (expire),
    .auto_restart(auto_restart),
    .irq_flag    (irq_flag),
    .running     (running),
    .gate_open   (gate_open),
    .reload      (reload),
    .cnt_q       (cnt_q)
);

// File: tb/ptimer_top_bench.sv
module ptimer_top_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_now = 0, stop_now = 0, tx_end = 0, rx_bit5 = 0;
    logic auto_mode = 0, multi_rx = 0, auto_restart = 0;
    logic [1:0] gate_sel = 2'd0;
    logic gate_a = 0, gate_b = 0, even_div = 0, irq_clr = 0;
    logic [3:0] psc_hi = '0;
    logic [7:0] psc_lo = '0;
    logic [15:0] reload = '0;
    logic running, expire, irq_flag;
    logic [7:0] count_hi, count_lo;

    int n_checks = 0, n_fail = 0, n_exp = 0, cyc = 0;

    always #2 clk = ~clk;

    ptimer_top u_ptimer_top (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && expire) n_exp <= n_exp + 1;
    end

    function automatic int cnt();
        return {count_hi, count_lo};
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_now = 1; @(negedge clk); start_now = 0;
    endtask

    task automatic pulse_stop();
        stop_now = 1; @(negedge clk); stop_now = 0;
    endtask

    task automatic test_reset_r1();
        chk("R1 running", running, 0);
        chk("R1 irq", irq_flag, 0);
        chk("R1 count", cnt(), 0);
    endtask

    task automatic test_divide_r2();
        // P = 2, odd: divide by 5
        psc_hi = 0; psc_lo = 2; even_div = 0; reload = 100;
        pulse_start();
        chk("R3 load", cnt(), 100);
        wait_cyc(4); chk("R2 odd before", cnt(), 100);
        wait_cyc(1); chk("R2 odd tick", cnt(), 99);
        pulse_stop();
        // P = 2, even: divide by 6
        even_div = 1;
        pulse_start();
        wait_cyc(5); chk("R2 even before", cnt(), 100);
        wait_cyc(1); chk("R2 even tick", cnt(), 99);
        pulse_stop();
        // P = 256 from upper part: divide by 513
        even_div = 0; psc_hi = 1; psc_lo = 0; reload = 10;
        pulse_start();
        wait_cyc(512); chk("R2 split before", cnt(), 10);
        wait_cyc(1);   chk("R2 split tick", cnt(), 9);
        pulse_stop();
        psc_hi = 0; psc_lo = 0;
    endtask

    task automatic test_oneshot_r4();
        int e0;
        auto_restart = 0; reload = 3;
        e0 = n_exp;
        pulse_start();
        wait_cyc(2); chk("R4 count one", cnt(), 1);
        chk("R4 still running", running, 1);
        wait_cyc(1);
        chk("R4 zero", cnt(), 0);
        chk("R4 stopped", running, 0);
        chk("R4 irq", irq_flag, 1);
        chk("R4 one pulse", n_exp - e0, 1);
        wait_cyc(3); chk("R6 idle frozen", cnt(), 0);
    endtask

    task automatic test_irq_clear_r9();
        irq_clr = 1; @(negedge clk); irq_clr = 0;
        chk("R9 cleared", irq_flag, 0);
        reload = 1; auto_restart = 0;
        pulse_start();
        irq_clr = 1; @(negedge clk); irq_clr = 0;
        chk("R9 expiry wins", irq_flag, 1);
    endtask

    task automatic test_autorestart_r5();
        int e0;
        auto_restart = 1; reload = 3;
        e0 = n_exp;
        pulse_start();
        reload = 7;
        wait_cyc(9);
        chk("R5 reload count", cnt(), 3);
        chk("R5 pulses", n_exp - e0, 3);
        chk("R5 running", running, 1);
        wait_cyc(2); chk("R3 shadow kept", cnt(), 1);
        pulse_stop();
        pulse_start();
        chk("R3 new value", cnt(), 7);
        pulse_stop();
        auto_restart = 0;
    endtask

    task automatic test_stop_r6();
        reload = 50;
        pulse_start();
        wait_cyc(5); chk("R6 counted", cnt(), 45);
        pulse_stop();
        chk("R6 halted", running, 0);
        chk("R6 held", cnt(), 45);
        wait_cyc(5); chk("R6 still held", cnt(), 45);
        start_now = 1; stop_now = 1; @(negedge clk); start_now = 0; stop_now = 0;
        chk("R6 stop wins", running, 0);
        chk("R6 stop wins count", cnt(), 45);
    endtask

    task automatic test_auto_r7();
        reload = 20;
        auto_mode = 0;
        tx_end = 1; @(negedge clk); tx_end = 0;
        chk("R7 ignored off", running, 0);
        chk("R7 ignored count", cnt(), 45);
        auto_mode = 1;
        tx_end = 1; @(negedge clk); tx_end = 0;
        chk("R7 auto start", running, 1);
        chk("R7 auto load", cnt(), 20);
        multi_rx = 1;
        rx_bit5 = 1; @(negedge clk); rx_bit5 = 0;
        chk("R7 multi keeps", running, 1);
        multi_rx = 0;
        rx_bit5 = 1; @(negedge clk); rx_bit5 = 0;
        chk("R7 auto stop", running, 0);
        auto_mode = 0;
    endtask

    task automatic test_gate_r8();
        reload = 30; gate_sel = 2'd1; gate_a = 0; gate_b = 1;
        pulse_start();
        wait_cyc(4);
        chk("R8 paused count", cnt(), 30);
        chk("R8 paused running", running, 1);
        gate_a = 1;
        wait_cyc(3); chk("R8 gate_a open", cnt(), 27);
        gate_sel = 2'd2; gate_b = 0;
        wait_cyc(3); chk("R8 gate_b closed", cnt(), 27);
        gate_b = 1;
        wait_cyc(2); chk("R8 gate_b open", cnt(), 25);
        gate_sel = 2'd3; gate_a = 0; gate_b = 0;
        wait_cyc(2); chk("R8 sel3 ungated", cnt(), 23);
        pulse_stop();
        gate_sel = 2'd0;
    endtask

    task automatic test_bytes_r10();
        reload = 16'hA55A;
        pulse_start();
        chk("R10 high byte", count_hi, 8'hA5);
        chk("R10 low byte", count_lo, 8'h5A);
        pulse_stop();
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1;
        @(negedge clk);
        test_reset_r1();
        test_divide_r2();
        test_oneshot_r4();
        test_irq_clear_r9();
        test_autorestart_r5();
        test_stop_r6();
        test_auto_r7();
        test_gate_r8();
        test_bytes_r10();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below 150000", cyc);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule